// File: doc/BRIEF.md
# In-Place Pixel Read-Modify-Write Sequencer

This block drives a byte-wide frame memory over a 16-bit address bus and an 8-bit bidirectional data bus. Location 0 holds a pass count N, and the colour bytes follow from address 1 upward as red, green, blue triples. After reset the sequencer reads N once. It then walks the frame one pixel at a time. For each pixel it fetches the three colour bytes and gives them, with N, to an external arithmetic unit over three enable cycles. It latches the three results and writes them back over the bytes they came from.

When the last pixel of the frame is written, the sequencer stores N-1 at location 0 and starts the next pass at address 1 without reading N again. When the stored value reaches zero it halts and raises a done flag. The address comes from an up/down counter. A small step code controls it, and a clear input zeroes it.

Top module: `pixel_rmw_seq`

## Requirements
- R1: While `rst` is 1 the address is 0, and `mem_sel`, `pu_en` and `done` are all 0.
- R2: `mem_sel` = 0 means no memory access. When `mem_sel` is 1, `mem_rd` = 1 is a read and `mem_rd` = 0 is a write. The block drives `mem_data` only in write cycles.
- R3: The first access after reset reads N from address 0. If that value is 0 the block halts with no write at all.
- R4: Pixel k (k starting at 0) occupies addresses 1+3k (red), 2+3k (green) and 3+3k (blue). The three bytes are read in that order on consecutive accesses.
- R5: After each blue read, `pu_en` is high for three cycles with no memory access. The results `new_r`, `new_g` and `new_b` are captured in the first, second and third of those cycles, with `pu_n`, `pu_r`, `pu_g` and `pu_b` held stable.
- R6: The three results are written red, green, blue to the same three addresses the pixel was read from.
- R7: The address counter takes a 2-bit step: 00 holds, 10 subtracts 1, and 01 or 11 adds 1. A clear forces the address to 0.
- R8: After the blue write whose next address would equal 1 + 3 × `pix_count`, the block writes N-1 to address 0.
- R9: A pass after the first starts reading at address 1 and does not read N again. A run with initial count N and P pixels makes 1 + 3·P·N reads.
- R10: Once the stored count is 0, `done` stays 1 and `mem_sel` stays 0 until reset.
- R11: With `pix_count` = 0 each pass consists only of the count store, so a run makes exactly N writes.
- R12: No byte beyond address 3 × `pix_count` is ever written, and the address never exceeds 1 + 3 × `pix_count`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_count | input | CNT_W | Pixels in the frame, at most MAX_PIXELS |
| mem_addr | output | ADDR_W | Memory address |
| mem_data | inout | DATA_W | Bidirectional memory data |
| mem_sel | output | 1 | Memory access enable |
| mem_rd | output | 1 | 1 = read, 0 = write |
| pu_en | output | 1 | Arithmetic unit enable |
| pu_n | output | DATA_W | Current pass count to the arithmetic unit |
| pu_r | output | DATA_W | Fetched red byte |
| pu_g | output | DATA_W | Fetched green byte |
| pu_b | output | DATA_W | Fetched blue byte |
| new_r | input | DATA_W | Computed red result |
| new_g | input | DATA_W | Computed green result |
| new_b | input | DATA_W | Computed blue result |
| done | output | 1 | All passes finished |

## Verification
The bench builds the block with MAX_PIXELS = 4 and 16-bit addresses. It sweeps every frame size from 0 to 4 pixels against starting counts 0 to 3. This small configuration covers the empty frame, the zero-count halt, single and multi-pixel frames and repeated passes, all in a few hundred cycles. The arithmetic-unit model subtracts a different multiple of N from each channel, with saturation at zero. Because of that, a wrong latch slot, a write to the wrong address or a skipped pass each leave a distinct mismatch in the final memory image.

// File: rtl/pixel_rmw_pkg.sv
package pixel_rmw_pkg;

    // Sequencer states; the numeric order follows the access sequence.
    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_GET_N  = 4'd1,
        ST_GET_R  = 4'd2,
        ST_GET_G  = 4'd3,
        ST_GET_B  = 4'd4,
        ST_CALC_R = 4'd5,
        ST_CALC_G = 4'd6,
        ST_CALC_B = 4'd7,
        ST_PUT_R  = 4'd8,
        ST_PUT_G  = 4'd9,
        ST_PUT_B  = 4'd10,
        ST_PUT_N  = 4'd11,
        ST_HALT   = 4'd12
    } seq_state_e;

    // Address step codes (2'b11 also counts up).
    localparam logic [1:0] STEP_HOLD = 2'b00;
    localparam logic [1:0] STEP_UP   = 2'b01;
    localparam logic [1:0] STEP_DOWN = 2'b10;

endpackage

// File: rtl/pixel_rmw_addr_ctr.sv
module pixel_rmw_addr_ctr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [1:0]        step,
    output logic [ADDR_W-1:0] addr
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (clear) begin
            ctr_d.addr = '0;
        end else begin
            unique case (step)
                2'b00:   ctr_d.addr = ctr_q.addr;
                2'b10:   ctr_d.addr = ctr_q.addr - 1'b1;
                default: ctr_d.addr = ctr_q.addr + 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctr_q <= '0;
        else     ctr_q <= ctr_d;
    end

    assign addr = ctr_q.addr;

endmodule

// File: rtl/pixel_rmw_ctrl.sv
module pixel_rmw_ctrl
    import pixel_rmw_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] frame_end,
    input  logic              bus_zero,
    input  logic              n_is_one,
    output seq_state_e        state,
    output logic              ctr_clear,
    output logic [1:0]        step,
    output logic              mem_sel,
    output logic              mem_rd,
    output logic              wr_en,
    output logic              pu_en,
    output logic              done
);

    typedef struct packed {
        seq_state_e state;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic              frame_empty;
    logic              last_pixel;
    logic [ADDR_W-1:0] addr_next;

    assign frame_empty = (frame_end == ADDR_W'(1));
    assign addr_next   = addr + 1'b1;
    assign last_pixel  = (addr_next == frame_end);

    always_comb begin
        fsm_d     = fsm_q;
        ctr_clear = 1'b0;
        step      = STEP_HOLD;
        mem_sel   = 1'b0;
        mem_rd    = 1'b1;
        wr_en     = 1'b0;
        pu_en     = 1'b0;
        done      = 1'b0;
        unique case (fsm_q.state)
            ST_IDLE: begin
                ctr_clear   = 1'b1;
                fsm_d.state = ST_GET_N;
            end
            ST_GET_N: begin
                mem_sel = 1'b1;
                if (bus_zero) begin
                    fsm_d.state = ST_HALT;
                end else if (frame_empty) begin
                    ctr_clear   = 1'b1;
                    fsm_d.state = ST_PUT_N;
                end else begin
                    step        = STEP_UP;
                    fsm_d.state = ST_GET_R;
                end
            end
            ST_GET_R: begin
                mem_sel     = 1'b1;
                step        = STEP_UP;
                fsm_d.state = ST_GET_G;
            end
            ST_GET_G: begin
                mem_sel     = 1'b1;
                step        = STEP_UP;
                fsm_d.state = ST_GET_B;
            end
            ST_GET_B: begin
                mem_sel     = 1'b1;
                step        = STEP_UP;
                fsm_d.state = ST_CALC_R;
            end
            ST_CALC_R: begin
                pu_en       = 1'b1;
                step        = STEP_DOWN;
                fsm_d.state = ST_CALC_G;
            end
            ST_CALC_G: begin
                pu_en       = 1'b1;
                step        = STEP_DOWN;
                fsm_d.state = ST_CALC_B;
            end
            ST_CALC_B: begin
                pu_en       = 1'b1;
                step        = STEP_DOWN;
                fsm_d.state = ST_PUT_R;
            end
            ST_PUT_R: begin
                mem_sel     = 1'b1;
                mem_rd      = 1'b0;
                wr_en       = 1'b1;
                step        = STEP_UP;
                fsm_d.state = ST_PUT_G;
            end
            ST_PUT_G: begin
                mem_sel     = 1'b1;
                mem_rd      = 1'b0;
                wr_en       = 1'b1;
                step        = STEP_UP;
                fsm_d.state = ST_PUT_B;
            end
            ST_PUT_B: begin
                mem_sel = 1'b1;
                mem_rd  = 1'b0;
                wr_en   = 1'b1;
                if (last_pixel) begin
                    ctr_clear   = 1'b1;
                    fsm_d.state = ST_PUT_N;
                end else begin
                    step        = STEP_UP;
                    fsm_d.state = ST_GET_R;
                end
            end
            ST_PUT_N: begin
                mem_sel = 1'b1;
                mem_rd  = 1'b0;
                wr_en   = 1'b1;
                if (n_is_one) begin
                    fsm_d.state = ST_HALT;
                end else if (frame_empty) begin
                    fsm_d.state = ST_PUT_N;
                end else begin
                    step        = STEP_UP;
                    fsm_d.state = ST_GET_R;
                end
            end
            ST_HALT: begin
                done = 1'b1;
            end
            default: begin
                fsm_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) fsm_q.state <= ST_IDLE;
        else     fsm_q       <= fsm_d;
    end

    assign state = fsm_q.state;

endmodule

// File: rtl/pixel_rmw_regs.sv
module pixel_rmw_regs
    import pixel_rmw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0] res_r,
    input  logic [DATA_W-1:0] res_g,
    input  logic [DATA_W-1:0] res_b,
    output logic [DATA_W-1:0] cnt_n,
    output logic [DATA_W-1:0] pix_r,
    output logic [DATA_W-1:0] pix_g,
    output logic [DATA_W-1:0] pix_b,
    output logic [DATA_W-1:0] wr_data,
    output logic              bus_zero,
    output logic              n_is_one
);

    localparam int CHANS = 3;

    typedef struct packed {
        logic [DATA_W-1:0]            n;
        logic [CHANS-1:0][DATA_W-1:0] pix;
        logic [CHANS-1:0][DATA_W-1:0] res;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [CHANS-1:0][DATA_W-1:0] res_in;
    logic [CHANS-1:0]             fetch_sel;
    logic [CHANS-1:0]             calc_sel;
    logic [CHANS-1:0]             put_sel;

    assign res_in = {res_b, res_g, res_r};

    // Per-channel state decode: channel c has its own fetch, latch and write slot.
    for (genvar c = 0; c < CHANS; c++) begin : g_chan
        assign fetch_sel[c] = (state == seq_state_e'(int'(ST_GET_R)  + c));
        assign calc_sel[c]  = (state == seq_state_e'(int'(ST_CALC_R) + c));
        assign put_sel[c]   = (state == seq_state_e'(int'(ST_PUT_R)  + c));
    end

    always_comb begin
        regs_d  = regs_q;
        wr_data = regs_q.n - 1'b1;
        if (state == ST_GET_N) regs_d.n = bus_in;
        if (state == ST_PUT_N) regs_d.n = regs_q.n - 1'b1;
        for (int c = 0; c < CHANS; c++) begin
            if (fetch_sel[c]) regs_d.pix[c] = bus_in;
            if (calc_sel[c])  regs_d.res[c] = res_in[c];
            if (put_sel[c])   wr_data       = regs_q.res[c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign cnt_n    = regs_q.n;
    assign pix_r    = regs_q.pix[0];
    assign pix_g    = regs_q.pix[1];
    assign pix_b    = regs_q.pix[2];
    assign bus_zero = (bus_in == '0);
    assign n_is_one = (regs_q.n == DATA_W'(1));

endmodule

// File: rtl/pixel_rmw_seq.sv
module pixel_rmw_seq
    import pixel_rmw_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int MAX_PIXELS = 6750,
    localparam int CNT_W     = $clog2(MAX_PIXELS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  pix_count,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_data,
    output logic              mem_sel,
    output logic              mem_rd,
    output logic              pu_en,
    output logic [DATA_W-1:0] pu_n,
    output logic [DATA_W-1:0] pu_r,
    output logic [DATA_W-1:0] pu_g,
    output logic [DATA_W-1:0] pu_b,
    input  logic [DATA_W-1:0] new_r,
    input  logic [DATA_W-1:0] new_g,
    input  logic [DATA_W-1:0] new_b,
    output logic              done
);

    seq_state_e        state;
    logic              ctr_clear;
    logic [1:0]        step_code;
    logic              wr_en;
    logic              bus_zero;
    logic              n_is_one;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] frame_end;

    // One count byte at address 0, then three bytes per pixel.
    assign frame_end = ADDR_W'(32'(pix_count) * 3 + 1);

    pixel_rmw_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk   (clk),
        .rst   (rst),
        .clear (ctr_clear),
        .step  (step_code),
        .addr  (mem_addr)
    );

    pixel_rmw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .addr      (mem_addr),
        .frame_end (frame_end),
        .bus_zero  (bus_zero),
        .n_is_one  (n_is_one),
        .state     (state),
        .ctr_clear (ctr_clear),
        .step      (step_code),
        .mem_sel   (mem_sel),
        .mem_rd    (mem_rd),
        .wr_en     (wr_en),
        .pu_en     (pu_en),
        .done      (done)
    );

    pixel_rmw_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .bus_in   (mem_data),
        .res_r    (new_r),
        .res_g    (new_g),
        .res_b    (new_b),
        .cnt_n    (pu_n),
        .pix_r    (pu_r),
        .pix_g    (pu_g),
        .pix_b    (pu_b),
        .wr_data  (wr_data),
        .bus_zero (bus_zero),
        .n_is_one (n_is_one)
    );

    assign mem_data = wr_en ? wr_data : 'z;

endmodule

// File: rtl/pixel_rmw_seq_chk.sv
module pixel_rmw_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] frame_end,
    input logic              mem_sel,
    input logic              mem_rd,
    input logic              pu_en,
    input logic              done,
    input logic              ctr_clear,
    input logic [1:0]        step_code
);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mem_addr == '0 && !mem_sel && !pu_en && !done)); // R1

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (!ctr_clear && step_code[0]) |=> (mem_addr == $past(mem_addr) + 1'b1)); // R7

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!ctr_clear && step_code == 2'b10) |=> (mem_addr == $past(mem_addr) - 1'b1)); // R7

    AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctr_clear && step_code == 2'b00) |=> $stable(mem_addr)); // R7

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        ctr_clear |=> (mem_addr == '0)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        mem_addr <= frame_end); // R12

    AST_PU_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        pu_en |-> !mem_sel); // R5

    AST_PU_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(pu_en) |-> $past(mem_sel && mem_rd)); // R5

    AST_PU_BURST: assert property (@(posedge clk) disable iff (rst)
        $rose(pu_en) |=> pu_en); // R5

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && !mem_sel)); // R10

endmodule

bind pixel_rmw_seq pixel_rmw_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .frame_end (frame_end),
    .mem_sel   (mem_sel),
    .mem_rd    (mem_rd),
    .pu_en     (pu_en),
    .done      (done),
    .ctr_clear (ctr_clear),
    .step_code (step_code)
);

// File: tb/pixel_rmw_seq_bench.sv
`timescale 1ns/1ps
module pixel_rmw_seq_bench;

    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int MAX_PIXELS = 4;
    localparam int CNT_W      = $clog2(MAX_PIXELS + 1);
    localparam int MEM_N      = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [CNT_W-1:0]  pix_count = '0;
    wire  [ADDR_W-1:0] mem_addr;
    wire  [DATA_W-1:0] mem_data;
    wire               mem_sel, mem_rd, pu_en, done;
    wire  [DATA_W-1:0] pu_n, pu_r, pu_g, pu_b;
    wire  [DATA_W-1:0] new_r, new_g, new_b;

    int n0  = 0;
    int cfg = 0;
    int n_chk = 0;
    int n_err = 0;
    int n_rd, n_wr, n_pu;
    logic [DATA_W-1:0] mem [0:MEM_N-1];
    int expv [0:MEM_N-1];

    always #4 clk = ~clk;

    function automatic int seed_byte(int i, int n, int c);
        if (i == 0) return n;
        return (i * 29 + c * 13 + 60) % 256;
    endfunction

    function automatic int sat_int(int x, int k);
        return (x > k) ? x - k : 0;
    endfunction

    // Arithmetic-unit model: each channel subtracts a different multiple of N.
    assign new_r = DATA_W'(sat_int(int'(pu_r), int'(pu_n)));
    assign new_g = DATA_W'(sat_int(int'(pu_g), 2 * int'(pu_n)));
    assign new_b = DATA_W'(sat_int(int'(pu_b), 3 * int'(pu_n)));

    // Memory model: combinational read, clocked write, seeded during reset.
    assign mem_data = (mem_sel && mem_rd) ? mem[mem_addr[4:0]] : 'z;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_N; i++) mem[i] <= DATA_W'(seed_byte(i, n0, cfg));
        end else if (mem_sel && !mem_rd) begin
            mem[mem_addr[4:0]] <= mem_data;
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            n_rd = 0; n_wr = 0; n_pu = 0;
        end else begin
            if (mem_sel && mem_rd)  n_rd++;
            if (mem_sel && !mem_rd) n_wr++;
            if (pu_en)              n_pu++;
        end
    end

    pixel_rmw_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_PIXELS(MAX_PIXELS)
    ) u_pixel_rmw_seq (
        .clk(clk), .rst(rst), .pix_count(pix_count),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_sel(mem_sel), .mem_rd(mem_rd),
        .pu_en(pu_en), .pu_n(pu_n), .pu_r(pu_r), .pu_g(pu_g), .pu_b(pu_b),
        .new_r(new_r), .new_g(new_g), .new_b(new_b), .done(done)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s (N=%0d P=%0d): actual %0d expected %0d", tag, n0, int'(pix_count), act, exp);
        end
    endtask

    task automatic run_case(int n, int p);
        int waited;
        rst = 1'b1;
        n0 = n;
        cfg = n * 5 + p;
        pix_count = CNT_W'(p);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mem_addr == '0, "R1 address in reset", int'(mem_addr), 0);
        chk(!mem_sel, "R1 select in reset", int'(mem_sel), 0);
        chk(!pu_en, "R1 unit enable in reset", int'(pu_en), 0);
        chk(!done, "R1 done in reset", int'(done), 0);

        for (int i = 0; i < MEM_N; i++) expv[i] = seed_byte(i, n, cfg);
        for (int pass = n; pass >= 1; pass--) begin
            for (int k = 0; k < p; k++) begin
                expv[1 + 3 * k] = sat_int(expv[1 + 3 * k], pass);
                expv[2 + 3 * k] = sat_int(expv[2 + 3 * k], 2 * pass);
                expv[3 + 3 * k] = sat_int(expv[3 + 3 * k], 3 * pass);
            end
        end
        if (n > 0) expv[0] = 0;

        rst = 1'b0;
        waited = 0;
        while (!done && waited < 4000) begin
            @(negedge clk);
            waited++;
        end
        chk(done, "R10 halt reached", int'(done), 1);
        chk(n_rd == 1 + 3 * p * n, "R2 R3 R9 read count", n_rd, 1 + 3 * p * n);
        chk(n_wr == n * (3 * p + 1), "R8 R11 write count", n_wr, n * (3 * p + 1));
        chk(n_pu == 3 * p * n, "R5 unit enable cycles", n_pu, 3 * p * n);

        repeat (3) @(negedge clk);
        chk(done && !mem_sel, "R10 stays halted and idle", int'(done && !mem_sel), 1);
        chk(n_wr == n * (3 * p + 1), "R10 no write after halt", n_wr, n * (3 * p + 1));

        for (int i = 0; i < MEM_N; i++) begin
            if (i == 0)
                chk(int'(mem[i]) == expv[i], "R8 stored count", int'(mem[i]), expv[i]);
            else if (i <= 3 * p)
                chk(int'(mem[i]) == expv[i], "R4 R6 R7 pixel byte", int'(mem[i]), expv[i]);
            else
                chk(int'(mem[i]) == expv[i], "R12 byte outside frame", int'(mem[i]), expv[i]);
        end
    endtask

    initial begin
        for (int n = 0; n <= 3; n++) begin
            for (int p = 0; p <= MAX_PIXELS; p++) begin
                run_case(n, p);
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL R10 watchdog expired: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule